// File: doc/BRIEF.md
# Accelerator Scratch Memory Controller with Power-On Wipe

This block is the control shell of a public-key arithmetic engine. It owns a 894-word by 32-bit scratch array. A 32-bit bus host fills the array with operands and later reads the results back from it. Next to the array sit a control register, a status register and a flag-clear register, and the block drives one interrupt line. The arithmetic engine is outside this block. A stub takes its place: the stub finishes a fixed number of half-rate ticks after it is started.

When reset is released, the block writes zero into every word of the array, one word per bus clock. While this wipe runs, the host cannot enable the engine and the array is sealed from the host. The block also produces a clock enable at half the bus rate, which paces the engine.

Software writes operands, sets the enable bit, then sets the start bit. It then waits for the end-of-operation flag or the interrupt, and acknowledges the flag through the clear register.

Top module: `accel_mem_ctrl`

## Requirements
- R1: A word of the array is at byte offset 0x400 + 4*i, for i from 0 to 893. Read data appears on `bus_rdata` one clock after the request. An access at or above offset 0x400 + 4*894 reads 0 and its write changes nothing.
- R2: After reset is released, the wipe lasts exactly 894 clocks. During those clocks status bit 0 (busy) reads 1. After the wipe, every array word reads 0.
- R3: While the wipe runs, host reads of the array return 0 and host writes to the array are discarded.
- R4: Control bit 0 (enable) stays 0 when it is written during the wipe. After the wipe it takes the written value.
- R5: `core_ce` is 0 in the first clock after reset and then inverts on every bus clock.
- R6: Writing 1 to control bit 1 (start) launches the engine only if the enable bit already held 1 before that write and busy is 0. A launch holds busy at 1 for about 2*CORE_TICKS clocks. The start bit always reads 0.
- R7: When the engine finishes, status bit 1 (end-of-operation) becomes 1. It stays 1 until it is cleared through R9.
- R8: `irq` is a registered copy of (status bit 1 AND control bit 8, interrupt enable).
- R9: Writing 1 to bit 1 of the clear register at offset 0x008 clears status bit 1. Writing 0 there has no effect. If a clear and a finish happen in the same clock, the finish wins.
- R10: After reset, control reads 0 and `irq` is 0. Control is at offset 0x000 and status is at offset 0x004.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 13 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one clock after the request |
| core_ce | output | 1 | Half-rate clock enable for the engine |
| irq | output | 1 | Interrupt request |

## Verification
A wipe counter that stops early or late shows up as the wrong number of busy clocks in a status read that is held continuously from reset. Words left unwiped appear as nonzero data at the first array read after the wipe. A broken gate on the array during the wipe returns stale data from a high word within the first few clocks. A wrong enable or flag state appears at the next read of control or status. A wrong interrupt state appears on `irq` one clock after the flag or the interrupt enable changes.

// File: rtl/accel_mem_pkg.sv
package accel_mem_pkg;
  localparam int unsigned OFF_CTRL = 'h000;
  localparam int unsigned OFF_STAT = 'h004;
  localparam int unsigned OFF_CLR  = 'h008;
  localparam int unsigned RAM_BASE = 'h400;

  localparam int unsigned CB_EN    = 0;
  localparam int unsigned CB_START = 1;
  localparam int unsigned CB_IE    = 8;
  localparam int unsigned SB_BUSY  = 0;
  localparam int unsigned SB_EOO   = 1;

  typedef enum logic {RD_REG = 1'b0, RD_RAM = 1'b1} rd_src_e;
endpackage

// File: rtl/accel_scratch_ram.sv
module accel_scratch_ram #(
  parameter int DEPTH = 894,
  parameter int DW    = 32,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wd,
  output logic [DW-1:0] rd
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wd;
    rd <= mem[addr];
  end
endmodule

// File: rtl/accel_ram_sweep.sv
module accel_ram_sweep #(
  parameter int WORDS = 894,
  parameter int IW    = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst,
  output logic          active,
  output logic [IW-1:0] idx
);
  localparam logic [IW-1:0] LAST = IW'(WORDS - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b1;
      idx    <= '0;
    end else if (active) begin
      if (idx == LAST) active <= 1'b0;
      else             idx    <= idx + 1'b1;
    end
  end
endmodule

// File: rtl/accel_core_stub.sv
module accel_core_stub #(
  parameter int TICKS = 8,
  parameter int CW    = $clog2(TICKS + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic ce,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      done <= 1'b0;
      cnt  <= '0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy <= 1'b1;
        cnt  <= '0;
      end else if (busy && ce) begin
        if (cnt == LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/accel_mem_ctrl.sv
module accel_mem_ctrl
  import accel_mem_pkg::*;
#(
  parameter int WORDS      = 894,
  parameter int DW         = 32,
  parameter int ADDR_W     = 13,
  parameter int CORE_TICKS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              core_ce,
  output logic              irq
);
  localparam int IW      = $clog2(WORDS);
  localparam int RAM_END = RAM_BASE + 4 * WORDS;

  // Decode
  logic is_ctrl, is_stat, is_clr, is_ram, wr, rd;
  logic [ADDR_W-1:0] ram_off;
  logic [IW-1:0]     host_idx;

  assign wr       = bus_sel && bus_we;
  assign rd       = bus_sel && !bus_we;
  assign is_ctrl  = int'(bus_addr) == OFF_CTRL;
  assign is_stat  = int'(bus_addr) == OFF_STAT;
  assign is_clr   = int'(bus_addr) == OFF_CLR;
  assign is_ram   = int'(bus_addr) >= RAM_BASE && int'(bus_addr) < RAM_END;
  assign ram_off  = bus_addr - ADDR_W'(RAM_BASE);
  assign host_idx = IW'(ram_off >> 2);

  // Wipe sequencer and array
  logic          sweep_busy;
  logic [IW-1:0] sweep_idx;
  logic          ram_we;
  logic [IW-1:0] ram_a;
  logic [DW-1:0] ram_wd, ram_q;

  accel_ram_sweep #(.WORDS(WORDS), .IW(IW)) u_sweep (
    .clk(clk), .rst(rst), .active(sweep_busy), .idx(sweep_idx)
  );

  assign ram_we = sweep_busy || (wr && is_ram);
  assign ram_a  = sweep_busy ? sweep_idx : host_idx;
  assign ram_wd = sweep_busy ? '0 : bus_wdata;

  accel_scratch_ram #(.DEPTH(WORDS), .DW(DW), .AW(IW)) u_ram (
    .clk(clk), .we(ram_we), .addr(ram_a), .wd(ram_wd), .rd(ram_q)
  );

  // Half-rate enable and engine stub
  logic core_busy, core_done, start_ok;

  always_ff @(posedge clk) begin
    if (rst) core_ce <= 1'b0;
    else     core_ce <= !core_ce;
  end

  accel_core_stub #(.TICKS(CORE_TICKS)) u_core (
    .clk(clk), .rst(rst), .ce(core_ce), .start(start_ok),
    .busy(core_busy), .done(core_done)
  );

  // Registers
  logic ctrl_en, ctrl_ie, eoo_flag, busy_all, clr_hit;

  assign busy_all = sweep_busy || core_busy;
  assign start_ok = wr && is_ctrl && bus_wdata[CB_START] && ctrl_en && !busy_all;
  assign clr_hit  = wr && is_clr && bus_wdata[SB_EOO];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_en  <= 1'b0;
      ctrl_ie  <= 1'b0;
      eoo_flag <= 1'b0;
      irq      <= 1'b0;
    end else begin
      if (wr && is_ctrl) begin
        ctrl_ie <= bus_wdata[CB_IE];
        if (!sweep_busy) ctrl_en <= bus_wdata[CB_EN];
      end
      if (core_done)    eoo_flag <= 1'b1;
      else if (clr_hit) eoo_flag <= 1'b0;
      irq <= eoo_flag && ctrl_ie;
    end
  end

  // Read path
  rd_src_e       rsel_q;
  logic [DW-1:0] reg_q, reg_val;

  always_comb begin
    reg_val = '0;
    if (is_ctrl) begin
      reg_val[CB_EN] = ctrl_en;
      reg_val[CB_IE] = ctrl_ie;
    end else if (is_stat) begin
      reg_val[SB_BUSY] = busy_all;
      reg_val[SB_EOO]  = eoo_flag;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsel_q <= RD_REG;
      reg_q  <= '0;
    end else if (rd) begin
      rsel_q <= (is_ram && !sweep_busy) ? RD_RAM : RD_REG;
      reg_q  <= reg_val;
    end
  end

  assign bus_rdata = (rsel_q == RD_RAM) ? ram_q : reg_q;
endmodule

// File: rtl/accel_mem_ctrl_chk.sv
module accel_mem_ctrl_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          sweep_busy,
  input logic          ctrl_en,
  input logic          ctrl_ie,
  input logic          eoo_flag,
  input logic          clr_hit,
  input logic          irq,
  input logic          core_ce,
  input logic          core_busy,
  input logic          ram_we,
  input logic [DW-1:0] ram_wd
);
  // R4
  a_r4_no_enable_in_wipe: assert property (@(posedge clk) disable iff (rst)
    sweep_busy |-> !ctrl_en);

  // R3
  a_r3_wipe_writes_zero: assert property (@(posedge clk) disable iff (rst)
    (sweep_busy && ram_we) |-> (ram_wd == '0));

  // R5
  a_r5_ce_toggles: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (core_ce != $past(core_ce)));

  // R6
  a_r6_launch_needs_enable: assert property (@(posedge clk) disable iff (rst)
    $rose(core_busy) |-> ($past(ctrl_en) && !$past(sweep_busy)));

  // R7
  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (eoo_flag && !clr_hit) |=> eoo_flag);

  // R8
  a_r8_irq_follows: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == $past(eoo_flag && ctrl_ie)));
endmodule

bind accel_mem_ctrl accel_mem_ctrl_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .sweep_busy(sweep_busy), .ctrl_en(ctrl_en),
  .ctrl_ie(ctrl_ie), .eoo_flag(eoo_flag), .clr_hit(clr_hit), .irq(irq),
  .core_ce(core_ce), .core_busy(core_busy), .ram_we(ram_we), .ram_wd(ram_wd)
);

// File: tb/accel_mem_ctrl_bench.sv
`timescale 1ns/1ps
module accel_mem_ctrl_bench;
  localparam int WORDS = 894;
  localparam int TICKS = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [12:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        core_ce, irq;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  always #2.5 clk = ~clk;

  accel_mem_ctrl #(.WORDS(WORDS), .CORE_TICKS(TICKS)) u_accel_mem_ctrl (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .core_ce(core_ce), .irq(irq)
  );

  // {word index, data}
  localparam logic [41:0] VEC [6] = '{
    {10'd0,   32'hA5A5_0001}, {10'd893, 32'h1234_5678},
    {10'd1,   32'hFFFF_FFFF}, {10'd447, 32'h0BAD_F00D},
    {10'd2,   32'h8000_0000}, {10'd892, 32'h0000_0001}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [12:0] waddr(input int i);
    return 13'(32'h400 + 4 * i);
  endfunction

  task automatic bus_write(input logic [12:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [12:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    int ones;
    int cyc;

    // R10 / R2: reset state and wipe length, with a status read held continuously
    repeat (2) @(negedge clk);
    chk("R10 irq in reset", {31'd0, irq}, 32'd0);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 13'h004;
    @(negedge clk);
    rst = 1'b0;
    ones = 0;
    for (int i = 0; i < 900; i++) begin
      @(negedge clk);
      if (bus_rdata[0]) ones++;
    end
    bus_sel = 1'b0;
    chk("R2 busy clocks of wipe", ones, WORDS);
    bus_read(13'h000, d);
    chk("R10 control after reset", d, 32'd0);
    chk("R10 irq after reset", {31'd0, irq}, 32'd0);
    bus_read(waddr(893), d);
    chk("R2 last word wiped", d, 32'd0);

    // R5: half-rate enable alternates
    for (int i = 0; i < 6; i++) begin
      logic prev;
      prev = core_ce;
      @(negedge clk);
      chk("R5 core_ce toggles", {31'd0, core_ce}, {31'd0, ~prev});
    end

    // R1: vector table walk
    foreach (VEC[i]) bus_write(waddr(int'(VEC[i][41:32])), VEC[i][31:0]);
    foreach (VEC[i]) begin
      bus_read(waddr(int'(VEC[i][41:32])), d);
      chk("R1 array readback", d, VEC[i][31:0]);
    end
    bus_write(waddr(WORDS), 32'hDEAD_BEEF);
    bus_read(waddr(WORDS), d);
    chk("R1 beyond last word", d, 32'd0);
    bus_read(waddr(0), d);
    chk("R1 word0 untouched", d, 32'hA5A5_0001);

    // R3 / R4: activity during the wipe
    do_reset();
    bus_write(13'h000, 32'h0000_0001);
    bus_read(waddr(893), d);
    chk("R3 read during wipe", d, 32'd0);
    bus_read(13'h000, d);
    chk("R4 enable held off in wipe", d, 32'd0);
    repeat (900) @(negedge clk);
    bus_read(waddr(447), d);
    chk("R2 middle word wiped", d, 32'd0);
    bus_read(waddr(893), d);
    chk("R2 high word wiped", d, 32'd0);
    bus_write(13'h000, 32'h0000_0000);

    // R6: start without enable
    bus_write(13'h000, 32'h0000_0002);
    bus_read(13'h004, d);
    chk("R6 start without enable", d, 32'd0);

    // R6: real launch
    bus_write(13'h000, 32'h0000_0001);
    bus_write(13'h000, 32'h0000_0103);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 13'h004;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (bus_rdata[0] && cyc < 100);
    bus_sel = 1'b0;
    checks++;
    if (cyc < 2*TICKS - 4 || cyc > 2*TICKS + 4) begin
      fails++;
      $display("FAIL R6 busy length actual=%0d expected=%0d", cyc, 2*TICKS);
    end
    bus_read(13'h000, d);
    chk("R6 start reads 0", d, 32'h0000_0101);
    repeat (3) @(negedge clk);
    bus_read(13'h004, d);
    chk("R7 flag set after finish", d, 32'h0000_0002);
    chk("R8 irq raised", {31'd0, irq}, 32'd1);

    // R9 / R8: clearing
    bus_write(13'h008, 32'h0000_0000);
    bus_read(13'h004, d);
    chk("R9 zero write no effect", d, 32'h0000_0002);
    bus_write(13'h000, 32'h0000_0001);
    @(negedge clk);
    chk("R8 irq masked", {31'd0, irq}, 32'd0);
    bus_read(13'h004, d);
    chk("R7 flag kept while masked", d, 32'h0000_0002);
    bus_write(13'h008, 32'h0000_0002);
    bus_read(13'h004, d);
    chk("R9 flag cleared", d, 32'd0);
    bus_write(13'h000, 32'h0000_0101);
    @(negedge clk);
    chk("R8 irq stays low", {31'd0, irq}, 32'd0);

    finish_run();
  end
endmodule